// File: doc/BRIEF.md
# D-PHY Test-Port Bring-up Sequencer

This block powers up a MIPI D-PHY from the controller side. It first programs a fixed list of internal PHY test codes through the PHY's 8-bit test-configuration port. Each list entry is an address byte and a value byte, and the list is set by parameters. Each entry is written in two phases. In the address phase the enable line is high and the address is latched on the falling edge of the test strobe. In the data phase the enable line is low and the value is latched on the rising edge of the strobe. The strobe's high and low times are a parameterised number of system clocks.

After the last entry is written, the block releases the PHY's power-down, its digital reset and its clock-lane enable, all three in the same cycle. It then polls PHY status: first for PLL lock, then for lock together with clock-lane stop state. Only when both hold does it raise the high-speed clock request and a ready flag. Each polling wait has its own timeout, and an expired timeout sends the block to a sticky error state.

The block also contains two helpers. One divides the byte clock down to an escape clock. The other presents the 2-bit code for the configured data-lane count.

Top module: `dphy_bringup_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `tst_clr` is 1. `pwr_down_n`, `dig_rst_n`, `lane_clk_en`, `tst_clk`, `hs_clk_req`, `ready` and `timeout_err` are all 0.
- R2: A `start` pulse in the idle state drives `tst_clr` to 0 in the next cycle. It stays 0 until the next reset.
- R3: Address phase: `tst_en` is 1 and `tst_din` carries the entry's address. `tst_clk` is high for exactly HALF cycles and then falls, and the address is taken on that falling edge. `tst_en` and `tst_din` do not change in a cycle where `tst_clk` changes.
- R4: Data phase: `tst_en` is 0 and `tst_din` carries the entry's value, which is taken on the rising edge of `tst_clk`. `tst_en` only falls while `tst_clk` is low.
- R5: Entries are written in list order. Entry i occupies bits [8i+7:8i] of both CODE_ADDRS and CODE_DATA. Exactly NUM_CODES address/value pairs are delivered.
- R6: After the last value is written, `pwr_down_n`, `dig_rst_n` and `lane_clk_en` rise in the same cycle and stay high. `tst_clk` never pulses after that.
- R7: `hs_clk_req` and `ready` rise only after `phy_lock` has been seen, and only in the cycle after `phy_lock` and `lane_stop` are both 1. With stop state already present, they follow `phy_lock` by two cycles.
- R8: If `phy_lock` stays 0 for LOCK_LIMIT cycles after release, or the lock-and-stop condition stays false for STOP_LIMIT cycles in the second wait, `timeout_err` becomes 1. It then stays 1, and `hs_clk_req` stays 0.
- R9: `esc_clk` has a period of `esc_div` byte clocks and is high for floor(`esc_div`/2) of them. `esc_div` values 0 and 1 hold `esc_clk` at 0.
- R10: `lane_cfg` equals LANES-1, so 2'b00 means one data lane and 2'b11 means four.
- R11: `start` outside the idle state has no effect. A pulse after ready causes no new writes and leaves `hs_clk_req` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the bring-up sequence |
| phy_lock | input | 1 | PHY PLL lock status |
| lane_stop | input | 1 | Clock lane in stop state |
| esc_div | input | 8 | Escape-clock division factor |
| tst_clr | output | 1 | Test-port clear, active high |
| tst_clk | output | 1 | Test-port strobe |
| tst_en | output | 1 | Test-port address/data selector |
| tst_din | output | 8 | Test-port data byte |
| pwr_down_n | output | 1 | PHY power-down release |
| dig_rst_n | output | 1 | PHY digital reset release |
| lane_clk_en | output | 1 | Clock-lane module enable |
| hs_clk_req | output | 1 | High-speed clock request |
| ready | output | 1 | Bring-up complete |
| timeout_err | output | 1 | A polling wait expired |
| esc_clk | output | 1 | Divided escape clock |
| lane_cfg | output | 2 | Encoded data-lane count |

## Verification
A writer phase counter that is wrong by one cycle shows up on the first strobe pulse. It makes the high time differ from HALF, and it moves `tst_din` or `tst_en` onto a strobe edge, so a PHY model sampling the pins sees it within a few hundred cycles of `start`. An index or list-selection fault produces a wrong or reordered address/value pair, or a missing one, by the time the power controls are released. Timer errors show as `timeout_err` arriving one cycle early or late against a count that starts at the release edge. The divider's state is visible only through `esc_clk`, so each division factor is judged from one full period and its high time.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CLR,
        SEQ_WRITE,
        SEQ_WAIT_LOCK,
        SEQ_WAIT_STOP,
        SEQ_HS_ON,
        SEQ_FAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        WP_IDLE,
        WP_ASET,
        WP_AHI,
        WP_ALO,
        WP_DSET,
        WP_DHI,
        WP_DLO
    } wr_phase_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } tcode_t;

    typedef struct packed {
        logic pwr_n;
        logic rst_n;
        logic clk_en;
    } pwr_ctrl_t;

    function automatic logic [1:0] lane_field(input int lanes);
        return 2'(lanes - 1);
    endfunction

    function automatic logic phase_strobe(input wr_phase_t p);
        return (p == WP_AHI) || (p == WP_DHI);
    endfunction

    function automatic logic phase_is_addr(input wr_phase_t p);
        return (p == WP_ASET) || (p == WP_AHI) || (p == WP_ALO);
    endfunction

    function automatic wr_phase_t phase_after(input wr_phase_t p);
        case (p)
            WP_ASET: return WP_AHI;
            WP_AHI:  return WP_ALO;
            WP_ALO:  return WP_DSET;
            WP_DSET: return WP_DHI;
            WP_DHI:  return WP_DLO;
            default: return WP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dphy_tport_writer.sv
module dphy_tport_writer
    import dphy_seq_pkg::*;
#(
    parameter int unsigned HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  tcode_t     code,
    output logic       busy,
    output logic       done,
    output logic       tst_clk,
    output logic       tst_en,
    output logic [7:0] tst_din
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] LASTC = HW'(HALF - 1);

    wr_phase_t   ph;
    logic [HW-1:0] cnt;
    logic [7:0]  din_q;
    logic [7:0]  dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= WP_IDLE;
            cnt   <= '0;
            din_q <= '0;
            dat_q <= '0;
        end else if (ph == WP_IDLE) begin
            cnt <= '0;
            if (go) begin
                ph    <= WP_ASET;
                din_q <= code.addr;
                dat_q <= code.data;
            end
        end else if (cnt == LASTC) begin
            cnt <= '0;
            ph  <= phase_after(ph);
            if (ph == WP_ALO) din_q <= dat_q;
            if (ph == WP_DLO) din_q <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy    = (ph != WP_IDLE);
    assign done    = (ph == WP_DLO) && (cnt == LASTC);
    assign tst_clk = phase_strobe(ph);
    assign tst_en  = phase_is_addr(ph);
    assign tst_din = din_q;

    // R3: selector and byte settle before and hold across every strobe edge
    assert_edge_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (tst_clk != $past(tst_clk)) |-> ($stable(tst_en) && $stable(tst_din)));

    // R3: strobe and selector idle low between writes
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tst_clk && !tst_en));

    // R4: selector drops only with strobe low
    assert_en_fall_low_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_en) |-> !tst_clk);

    // R5: sequencer never launches over a write in flight
    assert_go_idle_R5: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/dphy_poll_timer.sv
module dphy_poll_timer #(
    parameter int unsigned LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic met,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en || met) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign expired = en && !met && (cnt == LAST);

    // R8: the count is only ever nonzero inside an active wait
    assert_cnt_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (cnt == '0));

endmodule

// File: rtl/dphy_esc_div.sv
module dphy_esc_div (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] div,
    output logic       esc_clk
);
    logic [7:0] cnt;
    logic [7:0] nxt;
    logic       running;

    assign running = (div >= 8'd2);

    always_comb begin
        nxt = (cnt >= div - 8'd1) ? 8'd0 : cnt + 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            cnt     <= '0;
            esc_clk <= 1'b0;
        end else begin
            cnt     <= nxt;
            esc_clk <= (nxt < {1'b0, div[7:1]});
        end
    end

    // R9: factors 0 and 1 stop the escape clock
    assert_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (div < 8'd2) |=> !esc_clk);

endmodule

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq
    import dphy_seq_pkg::*;
#(
    parameter int unsigned NUM_CODES  = 3,
    parameter logic [NUM_CODES*8-1:0] CODE_ADDRS = 24'h22_10_44,
    parameter logic [NUM_CODES*8-1:0] CODE_DATA  = 24'h3C_81_74,
    parameter int unsigned HALF       = 2,
    parameter int unsigned LOCK_LIMIT = 4096,
    parameter int unsigned STOP_LIMIT = 4096,
    parameter int unsigned LANES      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       phy_lock,
    input  logic       lane_stop,
    input  logic [7:0] esc_div,
    output logic       tst_clr,
    output logic       tst_clk,
    output logic       tst_en,
    output logic [7:0] tst_din,
    output logic       pwr_down_n,
    output logic       dig_rst_n,
    output logic       lane_clk_en,
    output logic       hs_clk_req,
    output logic       ready,
    output logic       timeout_err,
    output logic       esc_clk,
    output logic [1:0] lane_cfg
);
    localparam int IW = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CODES - 1);

    seq_state_t state;
    logic [IW-1:0] idx;
    logic       launch;
    logic       wr_go, wr_busy, wr_done;
    tcode_t     cur;
    logic       released;
    pwr_ctrl_t  pwr;
    logic       lock_exp, stop_exp;
    logic       both_ok;

    assign both_ok  = phy_lock && lane_stop;
    assign cur.addr = CODE_ADDRS[int'(idx)*8 +: 8];
    assign cur.data = CODE_DATA[int'(idx)*8 +: 8];
    assign wr_go    = launch && (state == SEQ_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            launch <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) state <= SEQ_CLR;
                SEQ_CLR: begin
                    state  <= SEQ_WRITE;
                    idx    <= '0;
                    launch <= 1'b1;
                end
                SEQ_WRITE: begin
                    launch <= 1'b0;
                    if (wr_done) begin
                        if (idx == LAST_IDX) begin
                            state <= SEQ_WAIT_LOCK;
                        end else begin
                            idx    <= idx + 1'b1;
                            launch <= 1'b1;
                        end
                    end
                end
                SEQ_WAIT_LOCK: begin
                    if (phy_lock)      state <= SEQ_WAIT_STOP;
                    else if (lock_exp) state <= SEQ_FAIL;
                end
                SEQ_WAIT_STOP: begin
                    if (both_ok)       state <= SEQ_HS_ON;
                    else if (stop_exp) state <= SEQ_FAIL;
                end
                default: state <= state;
            endcase
        end
    end

    dphy_tport_writer #(.HALF(HALF)) u_writer (
        .clk(clk), .rst(rst), .go(wr_go), .code(cur),
        .busy(wr_busy), .done(wr_done),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din)
    );

    dphy_poll_timer #(.LIMIT(LOCK_LIMIT)) u_lock_tmr (
        .clk(clk), .rst(rst), .en(state == SEQ_WAIT_LOCK),
        .met(phy_lock), .expired(lock_exp)
    );

    dphy_poll_timer #(.LIMIT(STOP_LIMIT)) u_stop_tmr (
        .clk(clk), .rst(rst), .en(state == SEQ_WAIT_STOP),
        .met(both_ok), .expired(stop_exp)
    );

    dphy_esc_div u_esc (
        .clk(clk), .rst(rst), .div(esc_div), .esc_clk(esc_clk)
    );

    assign released    = (state == SEQ_WAIT_LOCK) || (state == SEQ_WAIT_STOP) ||
                         (state == SEQ_HS_ON) || (state == SEQ_FAIL);
    assign pwr         = released ? '{pwr_n: 1'b1, rst_n: 1'b1, clk_en: 1'b1} : '0;
    assign pwr_down_n  = pwr.pwr_n;
    assign dig_rst_n   = pwr.rst_n;
    assign lane_clk_en = pwr.clk_en;
    assign tst_clr     = (state == SEQ_IDLE);
    assign hs_clk_req  = (state == SEQ_HS_ON);
    assign ready       = (state == SEQ_HS_ON);
    assign timeout_err = (state == SEQ_FAIL);
    assign lane_cfg    = lane_field(int'(LANES));

    // R2: clear drops only in answer to start
    assert_clr_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_clr) |-> $past(start));

    // R2: once dropped, clear stays low
    assert_clr_stays_R2: assert property (@(posedge clk) disable iff (rst)
        !tst_clr |=> !tst_clr);

    // R6: release follows the writer's final completion
    assert_release_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down_n) |-> $past(wr_done));

    // R6: the three controls stay released together
    assert_release_hold_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_down_n |=> (pwr_down_n && dig_rst_n && lane_clk_en));

    // R6: no strobe activity after release
    assert_no_strobe_after_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_down_n |-> !tst_clk);

    // R7: HS request only after lock and stop state together
    assert_hs_gated_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_clk_req) |-> $past(phy_lock && lane_stop));

    // R8: error excludes the HS request
    assert_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> (!hs_clk_req && !ready));

    // R11: a completed bring-up is not disturbed by start
    assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        hs_clk_req |=> hs_clk_req);

endmodule

// File: tb/test_dphy_bringup_seq.sv
module test_dphy_bringup_seq;
    localparam int NC = 4;
    localparam logic [NC*8-1:0] ADDRS = 32'h5A_C3_07_44;
    localparam logic [NC*8-1:0] DATAS = 32'h0F_E8_91_74;
    localparam int HALF = 3;
    localparam int LOCK_LIM = 20;
    localparam int STOP_LIM = 12;
    localparam int LANES = 3;

    typedef struct packed {
        logic [7:0] div;
        int         period;
        int         high;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{div: 8'd2,   period: 2,   high: 1},
        '{div: 8'd3,   period: 3,   high: 1},
        '{div: 8'd7,   period: 7,   high: 3},
        '{div: 8'd10,  period: 10,  high: 5},
        '{div: 8'd0,   period: 0,   high: 0},
        '{div: 8'd1,   period: 0,   high: 0},
        '{div: 8'd255, period: 255, high: 127},
        '{div: 8'd4,   period: 4,   high: 2}
    };

    logic clk = 0;
    logic rst = 1;
    logic start = 0, phy_lock = 0, lane_stop = 0;
    logic [7:0] esc_div = 0;
    logic tst_clr, tst_clk, tst_en, pwr_down_n, dig_rst_n, lane_clk_en;
    logic hs_clk_req, ready, timeout_err, esc_clk;
    logic [7:0] tst_din;
    logic [1:0] lane_cfg;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dphy_bringup_seq #(
        .NUM_CODES(NC), .CODE_ADDRS(ADDRS), .CODE_DATA(DATAS), .HALF(HALF),
        .LOCK_LIMIT(LOCK_LIM), .STOP_LIMIT(STOP_LIM), .LANES(LANES)
    ) i_dphy_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .phy_lock(phy_lock),
        .lane_stop(lane_stop), .esc_div(esc_div), .tst_clr(tst_clr),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din),
        .pwr_down_n(pwr_down_n), .dig_rst_n(dig_rst_n), .lane_clk_en(lane_clk_en),
        .hs_clk_req(hs_clk_req), .ready(ready), .timeout_err(timeout_err),
        .esc_clk(esc_clk), .lane_cfg(lane_cfg)
    );

    // PHY test-port model, sampled away from the active edge
    logic [7:0] m_addr [16];
    logic [7:0] m_data [16];
    int         m_cnt = 0;
    logic [7:0] m_latched = 0;
    logic       m_pclk = 0;
    logic       m_pen = 0;
    logic [7:0] m_pdin = 0;
    int         m_high = 0;
    int         m_width_bad = 0;
    int         m_hold_bad = 0;

    always @(negedge clk) begin
        if (rst) begin
            m_cnt = 0; m_high = 0; m_width_bad = 0; m_hold_bad = 0;
        end else begin
            if (tst_clk != m_pclk && (tst_en != m_pen || tst_din != m_pdin))
                m_hold_bad++;
            if (tst_clk && !m_pclk) begin
                m_high = 1;
                if (!tst_en && m_cnt < 16) begin
                    m_addr[m_cnt] = m_latched;
                    m_data[m_cnt] = tst_din;
                    m_cnt++;
                end
            end else if (tst_clk) begin
                m_high++;
            end else if (!tst_clk && m_pclk) begin
                if (m_high != HALF) m_width_bad++;
                if (tst_en) m_latched = tst_din;
            end
        end
        m_pclk = tst_clk; m_pen = tst_en; m_pdin = tst_din;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic lk, input logic st);
        rst = 1; start = 0; phy_lock = lk; lane_stop = st;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_release();
        for (int k = 0; k < 3000 && !pwr_down_n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // reset state
        do_reset(0, 0);
        chk("R1 tst_clr", tst_clr, 1);
        chk("R1 pwr_down_n", pwr_down_n, 0);
        chk("R1 dig_rst_n", dig_rst_n, 0);
        chk("R1 lane_clk_en", lane_clk_en, 0);
        chk("R1 tst_clk", tst_clk, 0);
        chk("R1 hs/ready/err", {hs_clk_req, ready, timeout_err}, 0);
        chk("R10 lane_cfg", lane_cfg, LANES - 1);

        // normal bring-up
        pulse_start();
        chk("R2 tst_clr low after start", tst_clr, 0);
        wait_release();
        chk("R6 pwr_down_n released", pwr_down_n, 1);
        chk("R6 dig_rst_n with release", dig_rst_n, 1);
        chk("R6 lane_clk_en with release", lane_clk_en, 1);
        chk("R5 pair count", m_cnt, NC);
        for (int i = 0; i < NC; i++) begin
            chk("R3 address in order", m_addr[i], ADDRS[i*8 +: 8]);
            chk("R4 value in order", m_data[i], DATAS[i*8 +: 8]);
        end
        chk("R3 strobe high width", m_width_bad, 0);
        chk("R3 stable around edges", m_hold_bad, 0);
        chk("R2 tst_clr still low", tst_clr, 0);
        lane_stop = 1;
        repeat (3) @(negedge clk);
        chk("R7 no HS without lock", hs_clk_req, 0);
        phy_lock = 1;
        @(negedge clk);
        chk("R7 HS not yet one cycle after lock", hs_clk_req, 0);
        @(negedge clk);
        chk("R7 HS two cycles after lock", hs_clk_req, 1);
        chk("R7 ready with HS", ready, 1);
        pulse_start();
        repeat (10) @(negedge clk);
        chk("R11 HS kept after late start", hs_clk_req, 1);
        chk("R11 no new writes", m_cnt, NC);
        chk("R11 tst_clr stays low", tst_clr, 0);
        chk("R6 controls held", {pwr_down_n, dig_rst_n, lane_clk_en}, 3'b111);

        // lock timeout
        do_reset(0, 0);
        pulse_start();
        wait_release();
        repeat (LOCK_LIM - 1) @(negedge clk);
        chk("R8 no lock error one cycle early", timeout_err, 0);
        @(negedge clk);
        chk("R8 lock timeout error", timeout_err, 1);
        chk("R8 no HS on error", hs_clk_req, 0);
        lane_stop = 1; phy_lock = 1;
        repeat (4) @(negedge clk);
        chk("R8 error sticky", {timeout_err, hs_clk_req}, 2'b10);

        // stop-state timeout with lock already present
        do_reset(1, 0);
        pulse_start();
        wait_release();
        repeat (STOP_LIM) @(negedge clk);
        chk("R8 no stop error one cycle early", timeout_err, 0);
        @(negedge clk);
        chk("R8 stop timeout error", timeout_err, 1);
        chk("R7 no HS without stop state", hs_clk_req, 0);

        // escape-clock divider vectors
        foreach (VEC[v]) begin
            logic prev;
            bit   found;
            int   p;
            int   h;
            esc_div = VEC[v].div;
            repeat (int'(VEC[v].div) * 2 + 6) @(negedge clk);
            p = 0; h = 0;
            if (VEC[v].period == 0) begin
                for (int k = 0; k < 30; k++) begin
                    @(negedge clk);
                    if (esc_clk) h++;
                end
                chk("R9 stopped divider high count", h, 0);
            end else begin
                prev = esc_clk; found = 0;
                for (int k = 0; k < 600 && !found; k++) begin
                    @(negedge clk);
                    if (esc_clk && !prev) found = 1;
                    prev = esc_clk;
                end
                found = 0;
                for (int k = 0; k < 600 && !found; k++) begin
                    if (esc_clk) h++;
                    p++;
                    @(negedge clk);
                    if (esc_clk && !prev) found = 1;
                    prev = esc_clk;
                end
                chk("R9 escape period", p, VEC[v].period);
                chk("R9 escape high time", h, VEC[v].high);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule